// File: doc/BRIEF.md
# Split-Mode Dual 8-Bit Timer

This block holds two 16-bit timer/counters, called A and B, that step on a machine-cycle strobe. Timer A can be switched from one 16-bit count into a split arrangement, where its two bytes run as independent 8-bit counters. In that arrangement the low byte keeps all of A's own controls: its run bit, its gate qualifier and its choice between the internal strobe and an external event pin. The high byte can only count machine cycles. It takes over timer B's run bit and timer B's overflow flag, so its wrap raises B's interrupt request.

While A is split, timer B has no flag of its own. It runs freely unless it is given the split code itself, which parks it. It keeps producing a one-cycle wrap pulse that rate-generation logic can use. Software reaches the control byte and the four counter bytes through a simple write port. The counters, flags and interrupt requests come out as ports.

Top module: `tmr_split_pair`

## Requirements
- R1: After reset, both counters, both flags, both interrupt requests and the wrap pulse read zero, and every control bit is clear.
- R2: A write with `wr_en_i` high stores `wr_data_i` at the clock edge. The addresses are 0 = control, 1 = A low byte, 2 = A high byte, 3 = B low byte and 4 = B high byte. A write to a counter byte replaces that byte, and the counter (or half) holding it skips its count step in that cycle. Control bits: 0 run A, 1 gate A, 2 external-count A, 3 split A, 4 run B, 5 split B, 6 flag A, 7 flag B.
- R3: With split A clear, A is one 16-bit counter. It steps under A's run, gate and source controls, and its wrap from 0xFFFF to 0x0000 sets flag A.
- R4: With split A set, A's low byte steps under A's own controls. Its wrap from 0xFF to 0x00 sets flag A and leaves the high byte untouched.
- R5: When external count A is set, A steps once for each falling edge of `ext_evt_i`. The pin passes through two flip-flops, and its level is sampled on each strobe. A pin that holds its level produces no step.
- R6: When gate A is set, A steps only while the two-flop-synchronised `ext_gate_i` is high.
- R7: With split A set, A's high byte steps on every strobe while run B is set, whatever the external-count bit holds. Its wrap from 0xFF to 0x00 sets flag B.
- R8: Timer B steps on each strobe when split B is clear and either split A or run B is set. With split A and split B both set, B holds its value. Clearing split B restarts it.
- R9: `b_ovf_pulse_o` is high for the one cycle after each B wrap from 0xFFFF to 0x0000, in every mode. A B wrap sets flag B only while split A is clear.
- R10: The flags are set by hardware. A control write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged. When a hardware set and a clear fall in the same cycle, the set wins.
- R11: `irq_a_o` and `irq_b_o` follow flag A and flag B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Machine-cycle strobe |
| ext_evt_i | input | 1 | External event pin, asynchronous |
| ext_gate_i | input | 1 | Gate pin for timer A, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| cnt_a_o | output | 16 | Timer A value, high byte above the low byte |
| cnt_b_o | output | 16 | Timer B value |
| flag_a_o | output | 1 | Timer A overflow flag |
| flag_b_o | output | 1 | Timer B overflow flag, borrowed while A is split |
| irq_a_o | output | 1 | Timer A interrupt request |
| irq_b_o | output | 1 | Timer B interrupt request |
| b_ovf_pulse_o | output | 1 | One-cycle pulse after each B wrap |

## Verification
A hardware flag set and a software clear of the same flag can land in one cycle. The bench provokes this by loading a byte with 0xFF and then, in the cycle of the wrapping strobe, writing the control byte with that flag bit at zero. After that edge the flag must still read one. Random runs repeat the collision many times by preloading counters near their wrap point and mixing in random control writes. A cycle-level model built from the requirements judges every flag and counter after each edge.

// File: rtl/tmr_split_pkg.sv
package tmr_split_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL = 3'd0,
        ADR_A_LO = 3'd1,
        ADR_A_HI = 3'd2,
        ADR_B_LO = 3'd3,
        ADR_B_HI = 3'd4
    } tmr_adr_e;

    typedef struct packed {
        logic flag_b;
        logic flag_a;
        logic split_b;
        logic run_b;
        logic split_a;
        logic ext_a;
        logic gate_a;
        logic run_a;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic lvl_i,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = tick_i ? lvl_i : prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign fall_o = tick_i & prev_q & ~lvl_i;

    AST_ONE_FALL_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R5

endmodule

// File: rtl/tmr_pair_core.sv
module tmr_pair_core
    import tmr_split_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              evt_fall_i,
    input  logic              gate_lvl_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [HALF_W-1:0] wr_data_i,
    output logic [2*HALF_W-1:0] cnt_a_o,
    output logic [2*HALF_W-1:0] cnt_b_o,
    output logic              flag_a_o,
    output logic              flag_b_o,
    output logic              pulse_o
);
    localparam int FULL_W = 2 * HALF_W;

    typedef struct packed {
        tmr_ctrl_t         ctrl;
        logic [HALF_W-1:0] a_lo;
        logic [HALF_W-1:0] a_hi;
        logic [HALF_W-1:0] b_lo;
        logic [HALF_W-1:0] b_hi;
        logic              pulse;
    } core_st_t;

    core_st_t st_d, st_q;

    logic wr_ctl, wr_alo, wr_ahi, wr_blo, wr_bhi;
    logic go_a, lo_step, hi_step, full_step, b_run, b_step;
    logic lo_ovf, hi_ovf, full_ovf, b_ovf, set_a, set_b;
    logic [FULL_W-1:0] a_full, b_full, a_full_nx, b_full_nx;
    tmr_ctrl_t wr_ctrl_v;

    always_comb begin
        wr_ctl = wr_en_i && (wr_addr_i == ADR_CTRL);
        wr_alo = wr_en_i && (wr_addr_i == ADR_A_LO);
        wr_ahi = wr_en_i && (wr_addr_i == ADR_A_HI);
        wr_blo = wr_en_i && (wr_addr_i == ADR_B_LO);
        wr_bhi = wr_en_i && (wr_addr_i == ADR_B_HI);
        wr_ctrl_v = tmr_ctrl_t'(wr_data_i[7:0]);

        a_full = {st_q.a_hi, st_q.a_lo};
        b_full = {st_q.b_hi, st_q.b_lo};

        go_a = tick_i && st_q.ctrl.run_a
               && (!st_q.ctrl.gate_a || gate_lvl_i)
               && (st_q.ctrl.ext_a ? evt_fall_i : 1'b1);

        lo_step   = st_q.ctrl.split_a && go_a && !wr_alo;
        hi_step   = st_q.ctrl.split_a && tick_i && st_q.ctrl.run_b && !wr_ahi;
        full_step = !st_q.ctrl.split_a && go_a && !wr_alo && !wr_ahi;
        lo_ovf    = lo_step && (&st_q.a_lo);
        hi_ovf    = hi_step && (&st_q.a_hi);
        full_ovf  = full_step && (&a_full);

        b_run  = !st_q.ctrl.split_b && (st_q.ctrl.split_a || st_q.ctrl.run_b);
        b_step = tick_i && b_run && !wr_blo && !wr_bhi;
        b_ovf  = b_step && (&b_full);

        set_a = st_q.ctrl.split_a ? lo_ovf : full_ovf;
        set_b = st_q.ctrl.split_a ? hi_ovf : b_ovf;

        a_full_nx = a_full + FULL_W'(1);
        b_full_nx = b_full + FULL_W'(1);

        st_d = st_q;
        if (lo_step)   st_d.a_lo = st_q.a_lo + HALF_W'(1);
        if (hi_step)   st_d.a_hi = st_q.a_hi + HALF_W'(1);
        if (full_step) {st_d.a_hi, st_d.a_lo} = a_full_nx;
        if (b_step)    {st_d.b_hi, st_d.b_lo} = b_full_nx;

        if (wr_alo) st_d.a_lo = wr_data_i;
        if (wr_ahi) st_d.a_hi = wr_data_i;
        if (wr_blo) st_d.b_lo = wr_data_i;
        if (wr_bhi) st_d.b_hi = wr_data_i;

        if (wr_ctl) begin
            st_d.ctrl.run_a   = wr_ctrl_v.run_a;
            st_d.ctrl.gate_a  = wr_ctrl_v.gate_a;
            st_d.ctrl.ext_a   = wr_ctrl_v.ext_a;
            st_d.ctrl.split_a = wr_ctrl_v.split_a;
            st_d.ctrl.run_b   = wr_ctrl_v.run_b;
            st_d.ctrl.split_b = wr_ctrl_v.split_b;
            st_d.ctrl.flag_a  = st_q.ctrl.flag_a & wr_ctrl_v.flag_a;
            st_d.ctrl.flag_b  = st_q.ctrl.flag_b & wr_ctrl_v.flag_b;
        end
        st_d.ctrl.flag_a = st_d.ctrl.flag_a | set_a;
        st_d.ctrl.flag_b = st_d.ctrl.flag_b | set_b;
        st_d.pulse = b_ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_a_o  = {st_q.a_hi, st_q.a_lo};
    assign cnt_b_o  = {st_q.b_hi, st_q.b_lo};
    assign flag_a_o = st_q.ctrl.flag_a;
    assign flag_b_o = st_q.ctrl.flag_b;
    assign pulse_o  = st_q.pulse;

    AST_A_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.ctrl.flag_a) |-> (st_q.a_lo == '0)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctrl.flag_a && !(wr_ctl && !wr_data_i[6])) |=> st_q.ctrl.flag_a); // R10

    AST_HI_HOLD_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctrl.split_a && !st_q.ctrl.run_b && !wr_ahi) |=> $stable(st_q.a_hi)); // R7

    AST_B_FLAG_FROM_HI: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q.ctrl.flag_b) && $past(st_q.ctrl.split_a)) |-> (st_q.a_hi == '0)); // R7

    AST_B_PARKED: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctrl.split_a && st_q.ctrl.split_b && !wr_blo && !wr_bhi)
        |=> $stable({st_q.b_hi, st_q.b_lo})); // R8

    AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |-> ({st_q.b_hi, st_q.b_lo} == '0)); // R9

endmodule

// File: rtl/tmr_split_pair.sv
module tmr_split_pair #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                ext_evt_i,
    input  logic                ext_gate_i,
    input  logic                wr_en_i,
    input  logic [2:0]          wr_addr_i,
    input  logic [HALF_W-1:0]   wr_data_i,
    output logic [2*HALF_W-1:0] cnt_a_o,
    output logic [2*HALF_W-1:0] cnt_b_o,
    output logic                flag_a_o,
    output logic                flag_b_o,
    output logic                irq_a_o,
    output logic                irq_b_o,
    output logic                b_ovf_pulse_o
);
    logic [1:0] pins_sync;
    logic       evt_fall;

    tmr_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ext_gate_i, ext_evt_i}),
        .sync_o  (pins_sync)
    );

    tmr_fall_det u_fall (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .lvl_i  (pins_sync[0]),
        .fall_o (evt_fall)
    );

    tmr_pair_core #(.HALF_W(HALF_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .evt_fall_i (evt_fall),
        .gate_lvl_i (pins_sync[1]),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .cnt_a_o    (cnt_a_o),
        .cnt_b_o    (cnt_b_o),
        .flag_a_o   (flag_a_o),
        .flag_b_o   (flag_b_o),
        .pulse_o    (b_ovf_pulse_o)
    );

    assign irq_a_o = flag_a_o;
    assign irq_b_o = flag_b_o;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (irq_a_o == flag_a_o) && (irq_b_o == flag_b_o)); // R11

endmodule

// File: tb/tb_tmr_split_pair.sv
`timescale 1ns/1ps
module tb_tmr_split_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, ext = 1'b0, gate = 1'b0, we = 1'b0;
    logic [2:0]  wa = 3'd0;
    logic [7:0]  wd = 8'd0;
    logic [15:0] cnt_a, cnt_b;
    logic        flag_a, flag_b, irq_a, irq_b, pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_split_pair dut (
        .clk(clk), .rst(rst), .tick_i(tick), .ext_evt_i(ext), .ext_gate_i(gate),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
        .cnt_a_o(cnt_a), .cnt_b_o(cnt_b), .flag_a_o(flag_a), .flag_b_o(flag_b),
        .irq_a_o(irq_a), .irq_b_o(irq_b), .b_ovf_pulse_o(pulse)
    );

    // Reference model built from the requirements
    logic        m_s1, m_s2, m_g1, m_g2, m_prev, m_pulse;
    logic [7:0]  m_ctrl;
    logic [15:0] m_a, m_b;
    logic        t_fall, t_goa, t_brun, t_bovf, t_fa, t_fb;
    logic        t_wc, t_wal, t_wah, t_wbl, t_wbh;
    logic [15:0] t_na, t_nb;
    logic [7:0]  t_nc;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_g1 <= 0; m_g2 <= 0; m_prev <= 0; m_pulse <= 0;
            m_ctrl <= 0; m_a <= 0; m_b <= 0;
        end else begin
            t_wc  = we && wa == 3'd0;
            t_wal = we && wa == 3'd1;
            t_wah = we && wa == 3'd2;
            t_wbl = we && wa == 3'd3;
            t_wbh = we && wa == 3'd4;
            t_fall = tick && m_prev && !m_s2;
            t_goa  = tick && m_ctrl[0] && (!m_ctrl[1] || m_g2) && (m_ctrl[2] ? t_fall : 1'b1);
            t_na = m_a; t_nb = m_b; t_fa = 0; t_fb = 0;
            if (m_ctrl[3]) begin
                if (t_goa && !t_wal) begin
                    t_fa = (m_a[7:0] == 8'hFF);
                    t_na[7:0] = m_a[7:0] + 8'd1;
                end
                if (tick && m_ctrl[4] && !t_wah) begin
                    t_fb = (m_a[15:8] == 8'hFF);
                    t_na[15:8] = m_a[15:8] + 8'd1;
                end
            end else if (t_goa && !t_wal && !t_wah) begin
                t_fa = (m_a == 16'hFFFF);
                t_na = m_a + 16'd1;
            end
            t_brun = !m_ctrl[5] && (m_ctrl[3] || m_ctrl[4]);
            t_bovf = 0;
            if (tick && t_brun && !t_wbl && !t_wbh) begin
                t_bovf = (m_b == 16'hFFFF);
                t_nb = m_b + 16'd1;
            end
            if (!m_ctrl[3] && t_bovf) t_fb = 1;
            if (t_wal) t_na[7:0]  = wd;
            if (t_wah) t_na[15:8] = wd;
            if (t_wbl) t_nb[7:0]  = wd;
            if (t_wbh) t_nb[15:8] = wd;
            t_nc = m_ctrl;
            if (t_wc) begin
                t_nc[5:0] = wd[5:0];
                t_nc[6] = m_ctrl[6] & wd[6];
                t_nc[7] = m_ctrl[7] & wd[7];
            end
            t_nc[6] = t_nc[6] | t_fa;
            t_nc[7] = t_nc[7] | t_fb;
            m_s1 <= ext; m_s2 <= m_s1; m_g1 <= gate; m_g2 <= m_g1;
            if (tick) m_prev <= m_s2;
            m_ctrl <= t_nc; m_a <= t_na; m_b <= t_nb; m_pulse <= t_bovf;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk("R3/R4 cnt_a model", 32'(cnt_a), 32'(m_a));
        chk("R8 cnt_b model", 32'(cnt_b), 32'(m_b));
        chk("R10 flag_a model", 32'(flag_a), 32'(m_ctrl[6]));
        chk("R7 flag_b model", 32'(flag_b), 32'(m_ctrl[7]));
        chk("R11 irq model", 32'({irq_a, irq_b}), 32'(m_ctrl[7:6] == 2'b11 ? 2'b11 : {m_ctrl[6], m_ctrl[7]}));
        chk("R9 pulse model", 32'(pulse), 32'(m_pulse));
    endtask

    task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
        tick = t; we = w; wa = a; wd = d;
        @(negedge clk);
        cmp_model();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'd0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 cnt_a", 32'(cnt_a), 0);
        chk("R1 cnt_b", 32'(cnt_b), 0);
        chk("R1 flags", 32'({flag_a, flag_b, irq_a, irq_b, pulse}), 0);

        // R2: byte writes
        wr(3'd1, 8'h5A); wr(3'd2, 8'hC3); wr(3'd3, 8'h34); wr(3'd4, 8'h12);
        chk("R2 cnt_a write", 32'(cnt_a), 32'hC35A);
        chk("R2 cnt_b write", 32'(cnt_b), 32'h1234);

        // R4: low byte wrap in split mode, high byte untouched
        wr(3'd0, 8'h09); wr(3'd1, 8'hFE);
        step(1);
        chk("R4 low step", 32'(cnt_a), 32'hC3FF);
        step(1);
        chk("R4 low wrap", 32'(cnt_a), 32'hC300);
        chk("R4 flag_a set", 32'(flag_a), 1);
        chk("R11 irq_a", 32'(irq_a), 1);

        // R10: write 1 keeps, write 0 clears, set beats clear
        wr(3'd0, 8'h49);
        chk("R10 write one keeps", 32'(flag_a), 1);
        wr(3'd0, 8'h09);
        chk("R10 write zero clears", 32'(flag_a), 0);
        wr(3'd1, 8'hFF);
        cyc(1'b1, 1'b1, 3'd0, 8'h09);
        chk("R10 set wins over clear", 32'(flag_a), 1);
        chk("R10 low wrapped", 32'(cnt_a[7:0]), 0);

        // R7: high byte under borrowed run bit, ext-count bit irrelevant
        ext = 1'b1; idle(4);
        wr(3'd0, 8'h1D); wr(3'd2, 8'hFF); wr(3'd1, 8'h40);
        step(1);
        chk("R7 high wrap", 32'(cnt_a), 32'h0040);
        chk("R7 flag_b from high", 32'(flag_b), 1);
        step(3);
        chk("R7 high counts ticks", 32'(cnt_a[15:8]), 3);

        // R5: external falling edge, one step
        wr(3'd0, 8'h0D); wr(3'd1, 8'h10);
        step(3);
        chk("R5 no edge no step", 32'(cnt_a[7:0]), 32'h10);
        ext = 1'b0; step(6);
        chk("R5 one step per edge", 32'(cnt_a[7:0]), 32'h11);
        step(4);
        chk("R5 steady low no step", 32'(cnt_a[7:0]), 32'h11);

        // R8: B parked by its split code while A split, restarts afterwards
        wr(3'd0, 8'h28); wr(3'd3, 8'h00); wr(3'd4, 8'h01);
        step(3);
        chk("R8 B parked", 32'(cnt_b), 32'h0100);
        wr(3'd0, 8'h08);
        step(3);
        chk("R8 B restarted", 32'(cnt_b), 32'h0103);

        // R9: pulse in both modes; flag only when A not split
        wr(3'd0, 8'h10); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
        step(1);
        chk("R9 pulse", 32'(pulse), 1);
        chk("R9 flag_b from B wrap", 32'(flag_b), 1);
        step(1);
        chk("R9 pulse one cycle", 32'(pulse), 0);
        wr(3'd0, 8'h08); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
        chk("R9 flag_b cleared", 32'(flag_b), 0);
        step(1);
        chk("R9 pulse while borrowed", 32'(pulse), 1);
        chk("R9 no flag while borrowed", 32'(flag_b), 0);

        // R6: gate
        wr(3'd0, 8'h03); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        gate = 1'b0; step(4);
        chk("R6 gate low holds", 32'(cnt_a), 0);
        gate = 1'b1; idle(2); step(3);
        chk("R6 gate high counts", 32'(cnt_a), 3);

        // R3: 16-bit wrap
        wr(3'd0, 8'h01); wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
        step(1);
        chk("R3 16-bit step", 32'(cnt_a), 32'hFFFF);
        chk("R3 no flag yet", 32'(flag_a), 0);
        step(1);
        chk("R3 16-bit wrap", 32'(cnt_a), 0);
        chk("R3 flag_a", 32'(flag_a), 1);

        // Random phase, judged against the model
        void'($urandom(32'd7331));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            int r;
            r = int'($urandom_range(0, 15));
            if ($urandom_range(0, 19) == 0) ext = ~ext;
            if ($urandom_range(0, 29) == 0) gate = ~gate;
            case ($urandom_range(0, 3))
                0: d = 8'hFF;
                1: d = 8'hFE;
                default: d = 8'($urandom());
            endcase
            if (r < 2) cyc(1'($urandom()), 1'b1, 3'($urandom_range(0, 5)), d);
            else cyc(($urandom_range(0, 3) != 0), 1'b0, 3'd0, 8'd0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule